// File: doc/BRIEF.md
# Signature-Write Action Trigger

This block watches the stream of writes that a completer-side target engine has already accepted and turns a small set of special writes into outbound action requests. A write is special only when it lands in the first base address region (BAR identifier 0), at one of two fixed word offsets, with one of four exact 32-bit data values. The offset and data pair selects one of four actions: an upstream memory read, a legacy (wire-style) interrupt, an MSI, or an MSI-X. The write itself goes on to update the target memory as usual. This block only snoops the write and never stalls or alters it.

Each action has its own request/acknowledge pair toward the initiator that builds the outgoing packet or message. A request rises on the clock edge that samples the triggering write. It stays high until the initiator acknowledges it, and it falls on the edge that samples that acknowledge. While a request is outstanding, a further trigger of the same kind is dropped rather than queued. The four actions are independent, so several can be outstanding at once.

Top module: `sig_action_trigger`

## Requirements
- R1: A write with BAR identifier 0, offset 11'hEA8 and data 32'hAAAA_BBBB raises `rd_req` on the next clock edge.
- R2: A write with BAR identifier 0, offset 11'hEEC and data 32'hCCCC_DDDD raises `intx_req` on the next clock edge.
- R3: A write with BAR identifier 0, offset 11'hEEC and data 32'hEEEE_FFFF raises `msi_req` on the next clock edge.
- R4: A write with BAR identifier 0, offset 11'hEEC and data 32'hDEAD_BEEF raises `msix_req` on the next clock edge.
- R5: A write with any BAR identifier other than 0 raises no request, even when its offset and data match a signature.
- R6: A write whose data does not exactly match a signature, or whose offset differs from the offset paired with that data, raises no request.
- R7: A raised request stays high until its acknowledge is sampled high, and it is low from the clock edge that samples that acknowledge.
- R8: A trigger of a kind whose request is already high is dropped, including when it arrives in the same cycle as the acknowledge. An acknowledge while the request is low has no effect.
- R9: While `rst_n` is low, all four requests are low, and reset clears any outstanding request.
- R10: Offset and data values presented while `wr_valid` is low raise no request.
- R11: Requests of different kinds are independent: triggering or acknowledging one leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | An accepted write is present this cycle |
| wr_bar | input | 3 | BAR identifier the write decoded to |
| wr_offset | input | 11 | Byte offset of the write within the BAR |
| wr_data | input | 32 | Write data word |
| rd_req | output | 1 | Upstream memory read requested |
| rd_ack | input | 1 | Initiator accepted the memory read request |
| intx_req | output | 1 | Legacy interrupt requested |
| intx_ack | input | 1 | Initiator accepted the legacy interrupt request |
| msi_req | output | 1 | MSI requested |
| msi_ack | input | 1 | Initiator accepted the MSI request |
| msix_req | output | 1 | MSI-X requested |
| msix_ack | input | 1 | Initiator accepted the MSI-X request |

## Verification
The bench sends each signature write to every non-zero BAR identifier. A decoder that compared only offset and data would fire there. It also uses near-miss data, and signature data placed at the other trigger offset. These cases expose a compare that is too narrow or that ignores the offset-to-data pairing. A trigger is re-sent while the request is pending, both alone and in the same cycle as its acknowledge. A design that queued triggers, or that let a set override a clear, would then show a second request. The bench also checks that an acknowledge given while the request is idle does not suppress the next trigger. It checks that several kinds stay pending side by side, so that clearing one does not disturb the others.

// File: rtl/sig_trig_pkg.sv
package sig_trig_pkg;

    localparam int unsigned NUM_ACT = 4;
    localparam int unsigned BAR_W   = 3;
    localparam int unsigned OFS_W   = 11;
    localparam int unsigned DATA_W  = 32;

    // Index of each action in the request/acknowledge vectors.
    typedef enum logic [1:0] {
        ACT_RD   = 2'd0,
        ACT_INTX = 2'd1,
        ACT_MSI  = 2'd2,
        ACT_MSIX = 2'd3
    } act_e;

    // Signature table, indexed by act_e.
    localparam logic [NUM_ACT-1:0][OFS_W-1:0] SIG_OFS = {
        11'hEEC, 11'hEEC, 11'hEEC, 11'hEA8
    };
    localparam logic [NUM_ACT-1:0][DATA_W-1:0] SIG_DATA = {
        32'hDEAD_BEEF, 32'hEEEE_FFFF, 32'hCCCC_DDDD, 32'hAAAA_BBBB
    };

endpackage

// File: rtl/sig_trig_match.sv
module sig_trig_match
    import sig_trig_pkg::*;
#(
    parameter int unsigned                        N_ACT    = NUM_ACT,
    parameter int unsigned                        BW       = BAR_W,
    parameter int unsigned                        OW       = OFS_W,
    parameter int unsigned                        DW       = DATA_W,
    parameter logic [BW-1:0]                      HOME_BAR = '0,
    parameter logic [N_ACT-1:0][OW-1:0]           S_OFS    = SIG_OFS,
    parameter logic [N_ACT-1:0][DW-1:0]           S_DATA   = SIG_DATA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [BW-1:0]     wr_bar,
    input  logic [OW-1:0]     wr_offset,
    input  logic [DW-1:0]     wr_data,
    output logic [N_ACT-1:0]  hit
);

    logic in_home;

    always_comb begin
        in_home = wr_valid && (wr_bar == HOME_BAR);
    end

    for (genvar g = 0; g < N_ACT; g++) begin : g_sig
        always_comb begin
            hit[g] = in_home && (wr_offset == S_OFS[g]) && (wr_data == S_DATA[g]);
        end
    end

    // R11: one write selects at most one action
    p_single_hit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

    // R5: foreign BAR never matches
    p_home_bar_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_bar != HOME_BAR) |-> (hit == '0));

    // R10: idle bus never matches
    p_idle_no_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |-> (hit == '0));

endmodule

// File: rtl/sig_trig_pend.sv
module sig_trig_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic ack_i,
    output logic req_o
);

    typedef struct packed {
        logic req;
    } pend_t;

    pend_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.req) begin
            // Pending: a new trigger is dropped, only the acknowledge matters.
            if (ack_i) st_d.req = 1'b0;
        end else begin
            if (set_i) st_d.req = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_o = st_q.req;

    // R7: held until acknowledged
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ack_i) |=> req_o);

    // R7: acknowledge clears
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && ack_i) |=> !req_o);

    // R8: retrigger with ack does not re-arm
    p_no_rearm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && ack_i && set_i) |=> !req_o);

    // R1: idle plus trigger raises the request
    p_raise_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_o && set_i) |=> req_o);

    // R8: no request appears without a trigger
    p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_o && !set_i) |=> !req_o);

endmodule

// File: rtl/sig_action_trigger.sv
module sig_action_trigger
    import sig_trig_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_valid,
    input  logic [BAR_W-1:0]     wr_bar,
    input  logic [OFS_W-1:0]     wr_offset,
    input  logic [DATA_W-1:0]    wr_data,
    output logic                 rd_req,
    input  logic                 rd_ack,
    output logic                 intx_req,
    input  logic                 intx_ack,
    output logic                 msi_req,
    input  logic                 msi_ack,
    output logic                 msix_req,
    input  logic                 msix_ack
);

    logic [NUM_ACT-1:0] hit;
    logic [NUM_ACT-1:0] ack_vec;
    logic [NUM_ACT-1:0] req_vec;

    always_comb begin
        ack_vec           = '0;
        ack_vec[ACT_RD]   = rd_ack;
        ack_vec[ACT_INTX] = intx_ack;
        ack_vec[ACT_MSI]  = msi_ack;
        ack_vec[ACT_MSIX] = msix_ack;
    end

    sig_trig_match #(
        .N_ACT    (NUM_ACT),
        .BW       (BAR_W),
        .OW       (OFS_W),
        .DW       (DATA_W),
        .HOME_BAR ('0),
        .S_OFS    (SIG_OFS),
        .S_DATA   (SIG_DATA)
    ) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .wr_bar    (wr_bar),
        .wr_offset (wr_offset),
        .wr_data   (wr_data),
        .hit       (hit)
    );

    for (genvar g = 0; g < NUM_ACT; g++) begin : g_pend
        sig_trig_pend u_pend (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (hit[g]),
            .ack_i (ack_vec[g]),
            .req_o (req_vec[g])
        );
    end

    assign rd_req   = req_vec[ACT_RD];
    assign intx_req = req_vec[ACT_INTX];
    assign msi_req  = req_vec[ACT_MSI];
    assign msix_req = req_vec[ACT_MSIX];

    // R9: cleared by reset
    p_reset_clear_r9: assert property (@(posedge clk)
        !rst_n |=> (req_vec == '0));

    // R11: acknowledging one kind leaves an idle other kind idle without a hit
    p_independent_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!msi_req && !hit[ACT_MSI]) |=> !msi_req);

endmodule

// File: tb/sig_action_trigger_test.sv
module sig_action_trigger_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_valid;
    logic [2:0]  wr_bar;
    logic [10:0] wr_offset;
    logic [31:0] wr_data;
    logic        rd_req, intx_req, msi_req, msix_req;
    logic        rd_ack, intx_ack, msi_ack, msix_ack;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5ns clk = ~clk;

    sig_action_trigger uut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_bar(wr_bar),
        .wr_offset(wr_offset), .wr_data(wr_data),
        .rd_req(rd_req), .rd_ack(rd_ack), .intx_req(intx_req), .intx_ack(intx_ack),
        .msi_req(msi_req), .msi_ack(msi_ack), .msix_req(msix_req), .msix_ack(msix_ack)
    );

    // Vector order: {msix, msi, intx, rd}
    function automatic logic [3:0] reqs();
        return {msix_req, msi_req, intx_req, rd_req};
    endfunction

    task automatic chk(input string req, input logic [3:0] exp);
        checks++;
        if (reqs() !== exp) begin
            errors++;
            $display("FAIL %s: reqs=%b expected=%b", req, reqs(), exp);
        end
    endtask

    // One write cycle with an optional simultaneous acknowledge; result sampled
    // at the following falling edge, after the capturing rising edge.
    task automatic wr(input logic v, input logic [2:0] b, input logic [10:0] o,
                      input logic [31:0] d, input logic [3:0] ackv);
        @(negedge clk);
        wr_valid = v; wr_bar = b; wr_offset = o; wr_data = d;
        {msix_ack, msi_ack, intx_ack, rd_ack} = ackv;
        @(negedge clk);
        wr_valid = 1'b0; wr_bar = '0; wr_offset = '0; wr_data = '0;
        {msix_ack, msi_ack, intx_ack, rd_ack} = '0;
    endtask

    task automatic ack(input logic [3:0] ackv);
        wr(1'b0, 3'd0, 11'h0, 32'h0, ackv);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        wr(1'b1, 3'd0, 11'hEA8, 32'hAAAA_BBBB, 4'b0);
        chk("R9 reset holds requests low", 4'b0000);
        @(negedge clk) rst_n = 1'b1;
        chk("R9 state after reset", 4'b0000);
    endtask

    task automatic t_single(input string req, input logic [10:0] o,
                            input logic [31:0] d, input logic [3:0] bit_v);
        wr(1'b1, 3'd0, o, d, 4'b0);
        chk(req, bit_v);
        idle(3);
        chk("R7 request held without ack", bit_v);
        ack(bit_v);
        chk("R7 request cleared by ack", 4'b0000);
    endtask

    task automatic t_other_bar;
        for (int b = 1; b < 8; b++) begin
            wr(1'b1, 3'(b), 11'hEA8, 32'hAAAA_BBBB, 4'b0);
            wr(1'b1, 3'(b), 11'hEEC, 32'hCCCC_DDDD, 4'b0);
            wr(1'b1, 3'(b), 11'hEEC, 32'hEEEE_FFFF, 4'b0);
            wr(1'b1, 3'(b), 11'hEEC, 32'hDEAD_BEEF, 4'b0);
            chk("R5 non-zero BAR ignored", 4'b0000);
        end
    endtask

    task automatic t_mismatch;
        wr(1'b1, 3'd0, 11'hEEC, 32'hAAAA_BBBB, 4'b0);
        chk("R6 read signature at interrupt offset", 4'b0000);
        wr(1'b1, 3'd0, 11'hEA8, 32'hDEAD_BEEF, 4'b0);
        chk("R6 interrupt signature at read offset", 4'b0000);
        wr(1'b1, 3'd0, 11'hEEC, 32'hCCCC_DDDC, 4'b0);
        chk("R6 near-miss data", 4'b0000);
        wr(1'b1, 3'd0, 11'hEED, 32'hEEEE_FFFF, 4'b0);
        chk("R6 near-miss offset", 4'b0000);
        wr(1'b1, 3'd0, 11'hEA8, 32'h2AAA_BBBB, 4'b0);
        chk("R6 top-bit data miss", 4'b0000);
    endtask

    task automatic t_no_valid;
        wr(1'b0, 3'd0, 11'hEA8, 32'hAAAA_BBBB, 4'b0);
        wr(1'b0, 3'd0, 11'hEEC, 32'hDEAD_BEEF, 4'b0);
        chk("R10 fields without valid", 4'b0000);
    endtask

    task automatic t_retrigger;
        wr(1'b1, 3'd0, 11'hEEC, 32'hEEEE_FFFF, 4'b0);
        chk("R3 msi raised", 4'b0100);
        wr(1'b1, 3'd0, 11'hEEC, 32'hEEEE_FFFF, 4'b0);
        chk("R8 retrigger while pending", 4'b0100);
        ack(4'b0100);
        chk("R8 single ack clears after retrigger", 4'b0000);
        idle(2);
        chk("R8 no queued second request", 4'b0000);
        wr(1'b1, 3'd0, 11'hEEC, 32'hEEEE_FFFF, 4'b0);
        wr(1'b1, 3'd0, 11'hEEC, 32'hEEEE_FFFF, 4'b0100);
        chk("R8 trigger with ack while pending", 4'b0000);
        ack(4'b0001);
        chk("R8 ack while idle no effect", 4'b0000);
        wr(1'b1, 3'd0, 11'hEA8, 32'hAAAA_BBBB, 4'b0);
        chk("R8 trigger after idle ack", 4'b0001);
        ack(4'b0001);
        chk("R7 cleared", 4'b0000);
    endtask

    task automatic t_concurrent;
        wr(1'b1, 3'd0, 11'hEA8, 32'hAAAA_BBBB, 4'b0);
        wr(1'b1, 3'd0, 11'hEEC, 32'hCCCC_DDDD, 4'b0);
        chk("R11 two kinds pending", 4'b0011);
        wr(1'b1, 3'd0, 11'hEEC, 32'hDEAD_BEEF, 4'b0001);
        chk("R11 ack one while another triggers", 4'b1010);
        ack(4'b0010);
        chk("R11 ack legacy leaves msix", 4'b1000);
        ack(4'b1000);
        chk("R11 all cleared", 4'b0000);
    endtask

    task automatic t_reset_clear;
        wr(1'b1, 3'd0, 11'hEA8, 32'hAAAA_BBBB, 4'b0);
        wr(1'b1, 3'd0, 11'hEEC, 32'hCCCC_DDDD, 4'b0);
        wr(1'b1, 3'd0, 11'hEEC, 32'hEEEE_FFFF, 4'b0);
        wr(1'b1, 3'd0, 11'hEEC, 32'hDEAD_BEEF, 4'b0);
        chk("R11 all four pending", 4'b1111);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        chk("R9 reset clears pending", 4'b0000);
        rst_n = 1'b1;
        idle(1);
        chk("R9 stays clear after reset", 4'b0000);
    endtask

    initial begin
        rst_n = 1'b0; wr_valid = 1'b0; wr_bar = '0; wr_offset = '0; wr_data = '0;
        {msix_ack, msi_ack, intx_ack, rd_ack} = '0;
        t_reset();
        t_single("R1 memory read request", 11'hEA8, 32'hAAAA_BBBB, 4'b0001);
        t_single("R2 legacy interrupt request", 11'hEEC, 32'hCCCC_DDDD, 4'b0010);
        t_single("R3 msi request", 11'hEEC, 32'hEEEE_FFFF, 4'b0100);
        t_single("R4 msix request", 11'hEEC, 32'hDEAD_BEEF, 4'b1000);
        t_other_bar();
        t_mismatch();
        t_no_valid();
        t_retrigger();
        t_concurrent();
        t_reset_clear();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1ms;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule